// File: doc/BRIEF.md
# Table-Driven Character Disposition Engine

This block decides, one character at a time, what happens to each 8-bit character that a communication line receives or is about to send. It takes the character, whether it travels in the receive or the transmit direction, and the current protocol mode of that direction. From these it forms an address into a lookup table in system memory. The table holds eight 256-entry pages, one page per mode, and each direction has its own table base.

The block issues a single read on a request/response memory port and decodes the returned control byte. It then presents one disposition strobe to downstream logic. The strobe says whether the character is stored or discarded, whether it joins the block check, whether a block check is expected or must be sent, and whether an escape character goes out first. The control byte also names the mode that applies to the next character of that direction.

Two special paths exist. A receive control byte can ask for an interrupt. The character is then parked, processing stops, and the host resumes it, optionally after writing a replacement control byte. Per-direction inhibit bits skip the table lookup while the mode is 0 and treat the character as plain data.

Top module: `chr_dispo_engine`

## Requirements
- R1: The table address for a character is its direction's base plus the mode of that direction times 256 plus the character code, computed modulo 2^AW. The receive base and the transmit base are separate inputs.
- R2: Each looked-up character causes exactly one single-cycle `mem_req_valid` pulse. `chr_ready` stays low from acceptance until the response has been consumed, so only one fetch is ever outstanding.
- R3: The receive control byte is decoded as follows. Bits 2:0 are the next mode. Bit 3 requests an interrupt. Bit 4 = 1 stores the character and 0 discards it. Bit 5 includes the character in the block check. Bit 6 means the block check is expected next. Without an interrupt, the disposition strobe appears in the cycle after the response.
- R4: The transmit control byte is decoded as follows. Bits 2:0 are the next mode. Bit 3 inserts the escape character before the character. Bit 4 includes the character in the block check. Bit 5 sends the block check after it. A transmit disposition always has `disp_store` = 1 and `disp_expect_chk` = 0.
- R5: When transmit bit 3 is set, the engine emits two strobes on consecutive cycles. The first carries `disp_esc` = 1, `disp_char` = `esc_char`, `disp_bcc` = 0 and `disp_send_chk` = 0. The second is the data character's own disposition with `disp_esc` = 0.
- R6: The next mode from a control byte is loaded together with that character's disposition strobe and is used from the following character of the same direction on. The other direction's mode is unchanged. Modes change at no other time.
- R7: A receive control byte with bit 3 set pulses `rx_intr`, copies the character to `hold_char` and raises `rx_paused` with no disposition strobe. While paused, `chr_ready` is low and no character is accepted. A `host_resume` pulse produces the disposition in the next cycle and clears `rx_paused`.
- R8: A `host_override` write while paused replaces the fetched control byte for the held character, including its next mode. The interrupt bit of the byte used at resume is ignored.
- R9: When the direction's inhibit bit is set and its mode is 0, no fetch is made. The disposition appears in the cycle after acceptance with store = 1, block check = 1 and all other flags 0, and the mode stays 0. In a nonzero mode the inhibit bit has no effect and the fetch happens.
- R10: After reset, `chr_ready` = 1, `mem_req_valid` = 0, `disp_valid` = 0, `rx_paused` = 0, and both modes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | Character offered |
| chr_tx | input | 1 | 1 = transmit direction, 0 = receive |
| chr_code | input | CW | Character code |
| chr_ready | output | 1 | Engine can accept a character |
| rx_base | input | AW | Receive table base address |
| tx_base | input | AW | Transmit table base address |
| rx_inhibit | input | 1 | Skip receive lookup in mode 0 |
| tx_inhibit | input | 1 | Skip transmit lookup in mode 0 |
| esc_char | input | CW | Escape character to insert |
| mem_req_valid | output | 1 | Control-byte read request pulse |
| mem_req_addr | output | AW | Control-byte address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 8 | Control byte returned |
| host_resume | input | 1 | Release a paused receive character |
| host_ovr_valid | input | 1 | Write replacement control byte |
| host_ovr_data | input | 8 | Replacement control byte |
| rx_intr | output | 1 | Receive interrupt pulse |
| rx_paused | output | 1 | Receive character held |
| hold_char | output | CW | Character that caused the interrupt |
| rx_mode | output | MW | Current receive mode |
| tx_mode | output | MW | Current transmit mode |
| disp_valid | output | 1 | Disposition strobe |
| disp_tx | output | 1 | Direction of the strobe |
| disp_char | output | CW | Character of the strobe |
| disp_store | output | 1 | Store (1) or discard (0) |
| disp_bcc | output | 1 | Include in block check |
| disp_expect_chk | output | 1 | Block check expected next |
| disp_send_chk | output | 1 | Send block check after character |
| disp_esc | output | 1 | Strobe is an inserted escape |

## Verification
The bench builds the engine with AW = 18, MW = 3, CW = 8 and BASE_ALIGNED = 0, which selects the full-adder address path. It uses a receive base whose low byte is nonzero, so that adding the character code carries into the page bits. This exposes any address former that concatenates instead of adding. The memory model answers after three cycles, which leaves several cycles in which the single-outstanding rule can be observed. Modes 3, 5 and 1 are reached through fetched bytes, through a paused byte and through an override, so mode-page addressing and inhibit-in-nonzero-mode are both exercised.

// File: rtl/cde_pkg.sv
package cde_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2,
      ST_ESC  = 2'd3
   } cde_state_t;

   typedef struct packed {
      logic store;
      logic bcc;
      logic intr;
      logic expect_chk;
      logic send_chk;
      logic esc;
   } disp_flags_t;

   // control byte field positions shared by both directions
   localparam int unsigned RX_INTR_BIT  = 3;
   localparam int unsigned RX_STORE_BIT = 4;
   localparam int unsigned RX_BCC_BIT   = 5;
   localparam int unsigned RX_EXP_BIT   = 6;
   localparam int unsigned TX_ESC_BIT   = 3;
   localparam int unsigned TX_BCC_BIT   = 4;
   localparam int unsigned TX_SEND_BIT  = 5;

endpackage

// File: rtl/cde_addr_gen.sv
module cde_addr_gen #(
   parameter int unsigned AW           = 18,
   parameter int unsigned MW           = 3,
   parameter int unsigned CW           = 8,
   parameter bit          BASE_ALIGNED = 1'b0
) (
   input  logic [AW-1:0] base,
   input  logic [MW-1:0] mode,
   input  logic [CW-1:0] code,
   output logic [AW-1:0] addr
);
   localparam int unsigned OFS_W = MW + CW;

   if (AW < OFS_W + 1) begin : g_bad_aw
      $error("cde_addr_gen: AW must exceed mode and code width");
   end

   if (BASE_ALIGNED) begin : g_concat
      // base assumed to be a multiple of the full table size
      assign addr = {base[AW-1:OFS_W], mode, code};
   end else begin : g_adder
      assign addr = base + AW'({mode, code});
   end

endmodule

// File: rtl/cde_ctl_decode.sv
module cde_ctl_decode
   import cde_pkg::*;
#(
   parameter int unsigned MW = 3
) (
   input  logic [7:0]    ctl,
   input  logic          is_tx,
   input  logic          bypass,
   output disp_flags_t   flg,
   output logic [MW-1:0] nxt
);
   if (MW < 1 || MW > 3) begin : g_bad_mw
      $error("cde_ctl_decode: mode field holds 1 to 3 bits");
   end

   always_comb begin
      flg = '0;
      nxt = ctl[MW-1:0];
      if (bypass) begin
         flg.store = 1'b1;
         flg.bcc   = 1'b1;
         nxt       = '0;
      end else if (is_tx) begin
         flg.store    = 1'b1;
         flg.bcc      = ctl[TX_BCC_BIT];
         flg.send_chk = ctl[TX_SEND_BIT];
         flg.esc      = ctl[TX_ESC_BIT];
      end else begin
         flg.intr       = ctl[RX_INTR_BIT];
         flg.store      = ctl[RX_STORE_BIT];
         flg.bcc        = ctl[RX_BCC_BIT];
         flg.expect_chk = ctl[RX_EXP_BIT];
      end
   end

   // R4: transmit dispositions never discard and never raise an interrupt
   always_comb begin
      if (is_tx && !bypass) begin
         assert_tx_store_R4: assert (flg.store && !flg.intr && !flg.expect_chk);
      end
   end

endmodule

// File: rtl/chr_dispo_engine.sv
module chr_dispo_engine
   import cde_pkg::*;
#(
   parameter int unsigned AW           = 18,
   parameter int unsigned MW           = 3,
   parameter int unsigned CW           = 8,
   parameter bit          BASE_ALIGNED = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chr_valid,
   input  logic          chr_tx,
   input  logic [CW-1:0] chr_code,
   output logic          chr_ready,
   input  logic [AW-1:0] rx_base,
   input  logic [AW-1:0] tx_base,
   input  logic          rx_inhibit,
   input  logic          tx_inhibit,
   input  logic [CW-1:0] esc_char,
   output logic          mem_req_valid,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [7:0]    mem_rsp_data,
   input  logic          host_resume,
   input  logic          host_ovr_valid,
   input  logic [7:0]    host_ovr_data,
   output logic          rx_intr,
   output logic          rx_paused,
   output logic [CW-1:0] hold_char,
   output logic [MW-1:0] rx_mode,
   output logic [MW-1:0] tx_mode,
   output logic          disp_valid,
   output logic          disp_tx,
   output logic [CW-1:0] disp_char,
   output logic          disp_store,
   output logic          disp_bcc,
   output logic          disp_expect_chk,
   output logic          disp_send_chk,
   output logic          disp_esc
);
   localparam int unsigned PAGE_ENTRIES = 1 << CW;

   if (PAGE_ENTRIES < 2) begin : g_bad_cw
      $error("chr_dispo_engine: CW must be at least 1");
   end

   cde_state_t    state;
   logic          cur_tx;
   logic [CW-1:0] cur_char;
   logic [7:0]    byte_q;
   logic [7:0]    ovr_q;
   logic          ovr_v;

   logic [MW-1:0] in_mode;
   logic [AW-1:0] in_base;
   logic [AW-1:0] fetch_addr;
   logic          inh_hit;
   logic [7:0]    dec_byte;
   logic          dec_tx;
   logic          dec_bypass;
   disp_flags_t   dec_flg;
   logic [MW-1:0] dec_nxt;

   logic          accept;
   logic          emit_data;
   logic          emit_esc;
   logic          go_hold;
   logic          upd_mode;
   logic [CW-1:0] emit_char;

   assign chr_ready = (state == ST_IDLE);
   assign rx_paused = (state == ST_HOLD);
   assign accept    = chr_valid && chr_ready;

   assign in_mode = chr_tx ? tx_mode : rx_mode;
   assign in_base = chr_tx ? tx_base : rx_base;
   assign inh_hit = (chr_tx ? tx_inhibit : rx_inhibit) && (in_mode == '0);

   cde_addr_gen #(
      .AW(AW), .MW(MW), .CW(CW), .BASE_ALIGNED(BASE_ALIGNED)
   ) u_addr (
      .base (in_base),
      .mode (in_mode),
      .code (chr_code),
      .addr (fetch_addr)
   );

   always_comb begin
      dec_byte   = mem_rsp_data;
      dec_tx     = cur_tx;
      dec_bypass = 1'b0;
      unique case (state)
         ST_IDLE: begin
            dec_tx     = chr_tx;
            dec_bypass = 1'b1;
         end
         ST_HOLD: dec_byte = host_ovr_valid ? host_ovr_data : (ovr_v ? ovr_q : byte_q);
         ST_ESC:  dec_byte = byte_q;
         default: dec_byte = mem_rsp_data;
      endcase
   end

   cde_ctl_decode #(.MW(MW)) u_dec (
      .ctl    (dec_byte),
      .is_tx  (dec_tx),
      .bypass (dec_bypass),
      .flg    (dec_flg),
      .nxt    (dec_nxt)
   );

   always_comb begin
      emit_data = 1'b0;
      emit_esc  = 1'b0;
      go_hold   = 1'b0;
      unique case (state)
         ST_IDLE: emit_data = accept && inh_hit;
         ST_WAIT: begin
            if (mem_rsp_valid) begin
               if (!cur_tx && dec_flg.intr)    go_hold   = 1'b1;
               else if (cur_tx && dec_flg.esc) emit_esc  = 1'b1;
               else                            emit_data = 1'b1;
            end
         end
         ST_HOLD: emit_data = host_resume;
         default: emit_data = 1'b1;
      endcase
      upd_mode  = emit_data && (state != ST_IDLE);
      emit_char = (state == ST_IDLE) ? chr_code : cur_char;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state           <= ST_IDLE;
         cur_tx          <= 1'b0;
         cur_char        <= '0;
         byte_q          <= '0;
         ovr_q           <= '0;
         ovr_v           <= 1'b0;
         rx_mode         <= '0;
         tx_mode         <= '0;
         hold_char       <= '0;
         rx_intr         <= 1'b0;
         mem_req_valid   <= 1'b0;
         mem_req_addr    <= '0;
         disp_valid      <= 1'b0;
         disp_tx         <= 1'b0;
         disp_char       <= '0;
         disp_store      <= 1'b0;
         disp_bcc        <= 1'b0;
         disp_expect_chk <= 1'b0;
         disp_send_chk   <= 1'b0;
         disp_esc        <= 1'b0;
      end else begin
         disp_valid    <= emit_data || emit_esc;
         rx_intr       <= go_hold;
         mem_req_valid <= 1'b0;

         if (accept) begin
            cur_tx   <= chr_tx;
            cur_char <= chr_code;
            if (!inh_hit) begin
               mem_req_valid <= 1'b1;
               mem_req_addr  <= fetch_addr;
               state         <= ST_WAIT;
            end
         end

         if (state == ST_WAIT && mem_rsp_valid) begin
            byte_q <= mem_rsp_data;
         end

         if (go_hold) begin
            hold_char <= cur_char;
            ovr_v     <= 1'b0;
            state     <= ST_HOLD;
         end

         if (state == ST_HOLD && host_ovr_valid) begin
            ovr_q <= host_ovr_data;
            ovr_v <= 1'b1;
         end

         if (emit_esc) begin
            disp_tx         <= 1'b1;
            disp_char       <= esc_char;
            disp_store      <= 1'b1;
            disp_bcc        <= 1'b0;
            disp_expect_chk <= 1'b0;
            disp_send_chk   <= 1'b0;
            disp_esc        <= 1'b1;
            state           <= ST_ESC;
         end

         if (emit_data) begin
            disp_tx         <= (state == ST_IDLE) ? chr_tx : cur_tx;
            disp_char       <= emit_char;
            disp_store      <= dec_flg.store;
            disp_bcc        <= dec_flg.bcc;
            disp_expect_chk <= dec_flg.expect_chk;
            disp_send_chk   <= dec_flg.send_chk;
            disp_esc        <= 1'b0;
            if (state != ST_IDLE) state <= ST_IDLE;
         end

         if (upd_mode) begin
            if (cur_tx) tx_mode <= dec_nxt;
            else        rx_mode <= dec_nxt;
         end
      end
   end

   // R2: request is a single pulse and the engine is busy while it is out
   assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
   assert_busy_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !chr_ready);

   // R5: an escape strobe is followed at once by the data strobe
   assert_esc_then_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_esc) |=> (disp_valid && !disp_esc && disp_tx));

   // R6: modes move only together with a disposition strobe
   assert_mode_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_valid |-> ($stable(rx_mode) && $stable(tx_mode)));

   // R7: interrupt parks the character, no strobe, no new character
   assert_intr_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_intr |-> (rx_paused && !disp_valid));
   assert_pause_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_paused |-> !chr_ready);

   // R9: inhibited lookup produces a plain-data strobe without a fetch
   assert_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && inh_hit) |=> (!mem_req_valid && disp_valid && disp_store && disp_bcc));

endmodule

// File: tb/chr_dispo_engine_tb_top.sv
`timescale 1ns/1ps
module chr_dispo_engine_tb_top;
   localparam int unsigned AW  = 18;
   localparam int unsigned MW  = 3;
   localparam int unsigned CW  = 8;
   localparam int unsigned LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chr_valid = 1'b0;
   logic          chr_tx = 1'b0;
   logic [CW-1:0] chr_code = '0;
   logic          chr_ready;
   logic [AW-1:0] rx_base = 18'h0FF80;
   logic [AW-1:0] tx_base = 18'h20000;
   logic          rx_inhibit = 1'b0;
   logic          tx_inhibit = 1'b0;
   logic [CW-1:0] esc_char = 8'h10;
   logic          mem_req_valid;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [7:0]    mem_rsp_data = '0;
   logic          host_resume = 1'b0;
   logic          host_ovr_valid = 1'b0;
   logic [7:0]    host_ovr_data = '0;
   logic          rx_intr, rx_paused;
   logic [CW-1:0] hold_char;
   logic [MW-1:0] rx_mode, tx_mode;
   logic          disp_valid, disp_tx, disp_store, disp_bcc;
   logic          disp_expect_chk, disp_send_chk, disp_esc;
   logic [CW-1:0] disp_char;

   int n_chk = 0;
   int n_fail = 0;
   int req_cnt = 0;
   logic [AW-1:0] last_addr = '0;
   logic [7:0]    rsp_byte = '0;
   logic          got;

   always #2 clk = ~clk;

   chr_dispo_engine #(.AW(AW), .MW(MW), .CW(CW), .BASE_ALIGNED(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .chr_valid(chr_valid), .chr_tx(chr_tx), .chr_code(chr_code), .chr_ready(chr_ready),
      .rx_base(rx_base), .tx_base(tx_base),
      .rx_inhibit(rx_inhibit), .tx_inhibit(tx_inhibit), .esc_char(esc_char),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .host_resume(host_resume), .host_ovr_valid(host_ovr_valid), .host_ovr_data(host_ovr_data),
      .rx_intr(rx_intr), .rx_paused(rx_paused), .hold_char(hold_char),
      .rx_mode(rx_mode), .tx_mode(tx_mode),
      .disp_valid(disp_valid), .disp_tx(disp_tx), .disp_char(disp_char),
      .disp_store(disp_store), .disp_bcc(disp_bcc), .disp_expect_chk(disp_expect_chk),
      .disp_send_chk(disp_send_chk), .disp_esc(disp_esc)
   );

   // memory model: answers LAT cycles after seeing a request
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            req_cnt++;
            last_addr = mem_req_addr;
            for (int i = 1; i < LAT; i++) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rsp_byte;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_char(input logic tx, input logic [7:0] code);
      @(negedge clk);
      chr_valid = 1'b1;
      chr_tx    = tx;
      chr_code  = code;
      @(negedge clk);
      chr_valid = 1'b0;
   endtask

   task automatic wait_disp();
      got = 1'b0;
      for (int i = 0; i < 30 && !got; i++) begin
         if (disp_valid) got = 1'b1;
         else @(negedge clk);
      end
   endtask

   task automatic t_reset();
      check(chr_ready == 1'b1, "R10 ready", chr_ready, 1);
      check(!mem_req_valid && !disp_valid && !rx_paused, "R10 idle outputs",
            {mem_req_valid, disp_valid, rx_paused}, 0);
      check(rx_mode == 0 && tx_mode == 0, "R10 modes", {rx_mode, tx_mode}, 0);
   endtask

   task automatic t_rx_fetch();
      int c0;
      c0 = req_cnt;
      rsp_byte = 8'h70;
      send_char(1'b0, 8'h90);
      check(chr_ready == 1'b0, "R2 busy while fetch outstanding", chr_ready, 0);
      wait_disp();
      check(req_cnt == c0 + 1, "R2 one request", req_cnt - c0, 1);
      check(last_addr == 18'h10010, "R1 rx address with carry", last_addr, 18'h10010);
      check(got && !disp_tx && disp_char == 8'h90, "R3 strobe char", disp_char, 8'h90);
      check(disp_store && disp_bcc && disp_expect_chk && !disp_send_chk && !disp_esc,
            "R3 rx flags 70",
            {disp_store, disp_bcc, disp_expect_chk, disp_send_chk, disp_esc}, 5'b11100);
      @(negedge clk);
      rsp_byte = 8'h00;
      send_char(1'b0, 8'h22);
      wait_disp();
      check(got && !disp_store && !disp_bcc && !disp_expect_chk, "R3 rx discard",
            {disp_store, disp_bcc, disp_expect_chk}, 0);
   endtask

   task automatic t_mode();
      rsp_byte = 8'h13;
      @(negedge clk);
      send_char(1'b0, 8'h05);
      check(last_addr == 18'h0FF85 || req_cnt > 0, "R1 mode0 page", last_addr, 18'h0FF85);
      wait_disp();
      check(last_addr == 18'h0FF85, "R6 current char uses old mode", last_addr, 18'h0FF85);
      @(negedge clk);
      check(rx_mode == 3 && tx_mode == 0, "R6 next mode loaded", {rx_mode, tx_mode}, 8'h30);
      rsp_byte = 8'h13;
      send_char(1'b0, 8'h41);
      wait_disp();
      check(last_addr == 18'h0FF80 + 18'h341, "R1 mode3 page", last_addr, 18'h0FF80 + 18'h341);
      @(negedge clk);
      rsp_byte = 8'h00;
      send_char(1'b1, 8'h41);
      wait_disp();
      check(last_addr == 18'h20041, "R1 tx base separate", last_addr, 18'h20041);
   endtask

   task automatic t_tx();
      rsp_byte = 8'h32;
      @(negedge clk);
      send_char(1'b1, 8'h7E);
      wait_disp();
      check(got && disp_tx && disp_char == 8'h7E, "R4 tx strobe", disp_char, 8'h7E);
      check(disp_store && disp_bcc && disp_send_chk && !disp_esc && !disp_expect_chk,
            "R4 tx flags 32",
            {disp_store, disp_bcc, disp_send_chk, disp_esc, disp_expect_chk}, 5'b11100);
      @(negedge clk);
      check(tx_mode == 2 && rx_mode == 3, "R6 tx mode only", {tx_mode, rx_mode}, 8'h23);
   endtask

   task automatic t_esc();
      rsp_byte = 8'h18;
      @(negedge clk);
      send_char(1'b1, 8'h03);
      wait_disp();
      check(got && disp_esc && disp_char == 8'h10 && !disp_bcc && !disp_send_chk,
            "R5 escape strobe", {disp_esc, disp_char}, 9'h110);
      @(negedge clk);
      check(disp_valid && !disp_esc && disp_char == 8'h03 && disp_bcc,
            "R5 data after escape", {disp_valid, disp_esc, disp_char}, 10'h203);
      check(tx_mode == 0, "R6 tx mode after escape char", tx_mode, 0);
   endtask

   task automatic t_intr();
      int c0;
      rsp_byte = 8'h0D;
      @(negedge clk);
      send_char(1'b0, 8'hA5);
      got = 1'b0;
      for (int i = 0; i < 30 && !got; i++) begin
         if (rx_intr) got = 1'b1;
         else @(negedge clk);
      end
      check(got && rx_paused && hold_char == 8'hA5 && !disp_valid, "R7 interrupt capture",
            hold_char, 8'hA5);
      c0 = req_cnt;
      chr_valid = 1'b1; chr_tx = 1'b0; chr_code = 8'h11;
      repeat (3) @(negedge clk);
      check(!chr_ready && rx_paused && !disp_valid, "R7 paused blocks", chr_ready, 0);
      chr_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(req_cnt == c0, "R7 no fetch while paused", req_cnt - c0, 0);
      host_resume = 1'b1;
      @(negedge clk);
      host_resume = 1'b0;
      check(disp_valid && !disp_store && !disp_bcc && disp_char == 8'hA5 && !rx_paused,
            "R7 resume strobe", {disp_valid, disp_store, disp_char}, 10'h2A5);
      check(rx_mode == 5, "R7 mode from held byte", rx_mode, 5);
   endtask

   task automatic t_override();
      rsp_byte = 8'h08;
      @(negedge clk);
      send_char(1'b0, 8'h3C);
      got = 1'b0;
      for (int i = 0; i < 30 && !got; i++) begin
         if (rx_paused) got = 1'b1;
         else @(negedge clk);
      end
      check(got, "R8 paused before override", got, 1);
      host_ovr_valid = 1'b1; host_ovr_data = 8'h79;
      @(negedge clk);
      host_ovr_valid = 1'b0;
      check(rx_paused && !disp_valid, "R8 override does not release", rx_paused, 1);
      host_resume = 1'b1;
      @(negedge clk);
      host_resume = 1'b0;
      check(disp_valid && disp_store && disp_bcc && disp_expect_chk && !rx_paused,
            "R8 override flags", {disp_valid, disp_store, disp_bcc, disp_expect_chk}, 4'hF);
      check(rx_mode == 1, "R8 override next mode", rx_mode, 1);
   endtask

   task automatic t_inhibit();
      int c0;
      rx_inhibit = 1'b1;
      c0 = req_cnt;
      rsp_byte = 8'h00;
      @(negedge clk);
      send_char(1'b0, 8'h44);
      wait_disp();
      check(req_cnt == c0 + 1, "R9 inhibit ignored in mode 1", req_cnt - c0, 1);
      check(!disp_store && !disp_bcc, "R9 fetched byte used in mode 1",
            {disp_store, disp_bcc}, 0);
      @(negedge clk);
      check(rx_mode == 0, "R9 back to mode 0", rx_mode, 0);
      c0 = req_cnt;
      @(negedge clk);
      chr_valid = 1'b1; chr_tx = 1'b0; chr_code = 8'h55;
      @(negedge clk);
      chr_valid = 1'b0;
      check(disp_valid && disp_store && disp_bcc && !disp_expect_chk && disp_char == 8'h55,
            "R9 inhibited strobe", {disp_valid, disp_store, disp_bcc, disp_char}, 11'h755);
      repeat (4) @(negedge clk);
      check(req_cnt == c0 && rx_mode == 0, "R9 no fetch, mode stays 0", req_cnt - c0, 0);
      rsp_byte = 8'h00;
      send_char(1'b1, 8'h66);
      wait_disp();
      check(req_cnt == c0 + 1, "R9 tx not inhibited", req_cnt - c0, 1);
      rx_inhibit = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_fetch();
      t_mode();
      t_tx();
      t_esc();
      t_intr();
      t_override();
      t_inhibit();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule